// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a small register file of `WIDTH` flip-flops (four by default) whose contents move in one of four ways on every rising clock edge. A two-bit operation select picks the move: take a whole word from the parallel data inputs, move every bit one place toward the high end, move every bit one place toward the low end, or keep the word unchanged. Each shift direction has its own serial input, which fills the position left empty by the shift.

An active-low clear acts asynchronously and overrides every other input. While it is held low, clock edges have no effect and the register reads zero. The word is always visible on the parallel output. Bit 0 is position A and bit `WIDTH-1` is position D. Several blocks can therefore be chained: the high end bit feeds the next stage's right-shift serial input, and the low end bit feeds a previous stage's left-shift serial input.

Top module: `uni_shift_reg`

## Requirements
- R1: With `op_sel` = 2'b11 (load), the register takes `par_in` on the rising clock edge, with `q_out[i]` equal to `par_in[i]` after that edge.
- R2: During a load, the values on `ser_right_in` and `ser_left_in` have no effect on the loaded word.
- R3: With `op_sel` = 2'b01 (shift toward D), each rising edge moves `q_out[i-1]` into `q_out[i]` and puts `ser_right_in` into `q_out[0]`.
- R4: With `op_sel` = 2'b10 (shift toward A), each rising edge moves `q_out[i+1]` into `q_out[i]` and puts `ser_left_in` into `q_out[WIDTH-1]`.
- R5: With `op_sel` = 2'b00 (hold), no bit of `q_out` changes on a rising edge, whatever `par_in` and the serial inputs carry.
- R6: Driving `clr_n` low forces `q_out` to all zeros at once, with no clock edge needed.
- R7: While `clr_n` is low, rising clock edges leave `q_out` at zero in every mode. After `clr_n` returns high, operation resumes from zero at the next edge.
- R8: A bit entered at `ser_right_in` appears on `q_out[WIDTH-1]` after `WIDTH` right shifts. A bit entered at `ser_left_in` appears on `q_out[0]` after `WIDTH` left shifts. This is the carry used to chain stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all loads and shifts happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low, overrides everything |
| op_sel | input | 2 | Operation: 00 hold, 01 shift toward D, 10 shift toward A, 11 load |
| par_in | input | WIDTH | Parallel data word for the load operation |
| ser_right_in | input | 1 | Serial bit entering at position A (bit 0) on a shift toward D |
| ser_left_in | input | 1 | Serial bit entering at position D (bit WIDTH-1) on a shift toward A |
| q_out | output | WIDTH | Current register contents, bit 0 = A, bit WIDTH-1 = D |

## Verification
The bench builds the register at its default `WIDTH` of 4. At that width a fixed vector walk can load a word, step it fully out in either direction within four edges, and cover every operation code next to every other one. Long randomized runs then exercise most of the 16 possible contents, compared against a behavioural model. Those runs include clears that land between clock edges, so that clear priority is tested while the register holds nonzero data.

// File: rtl/usr_pkg.sv
package usr_pkg;

    // Operation codes; the encoding is part of the block's interface
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_RIGHT = 2'b01,
        OP_LEFT  = 2'b10,
        OP_LOAD  = 2'b11
    } usr_op_e;

endpackage

// File: rtl/usr_op_decode.sv
module usr_op_decode
    import usr_pkg::*;
(
    input  logic [1:0] op_sel,
    output usr_op_e    op
);

    always_comb begin
        unique case (op_sel)
            2'b01:   op = OP_RIGHT;
            2'b10:   op = OP_LEFT;
            2'b11:   op = OP_LOAD;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/usr_bit_next.sv
module usr_bit_next
    import usr_pkg::*;
(
    input  usr_op_e op,
    input  logic    cur_bit,
    input  logic    load_bit,
    input  logic    lower_bit,
    input  logic    upper_bit,
    output logic    next_bit
);

    // lower_bit feeds in on a shift toward D, upper_bit on a shift toward A
    always_comb begin
        unique case (op)
            OP_LOAD:  next_bit = load_bit;
            OP_RIGHT: next_bit = lower_bit;
            OP_LEFT:  next_bit = upper_bit;
            default:  next_bit = cur_bit;
        endcase
    end

endmodule

// File: rtl/uni_shift_reg.sv
module uni_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_right_in,
    input  logic             ser_left_in,
    output logic [WIDTH-1:0] q_out
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } usr_state_t;

    usr_state_t       state_d, state_q;
    usr_op_e          op;
    logic [WIDTH-1:0] bit_nxt;
    logic [WIDTH-1:0] from_lower;
    logic [WIDTH-1:0] from_upper;

    usr_op_decode u_dec (
        .op_sel (op_sel),
        .op     (op)
    );

    // Neighbour wiring; the serial inputs fill the two end positions
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            if (i == 0) begin : g_low_end
                assign from_lower[i] = ser_right_in;
            end else begin : g_low_mid
                assign from_lower[i] = state_q.bits[i-1];
            end
            if (i == TOP) begin : g_high_end
                assign from_upper[i] = ser_left_in;
            end else begin : g_high_mid
                assign from_upper[i] = state_q.bits[i+1];
            end

            usr_bit_next u_bit (
                .op        (op),
                .cur_bit   (state_q.bits[i]),
                .load_bit  (par_in[i]),
                .lower_bit (from_lower[i]),
                .upper_bit (from_upper[i]),
                .next_bit  (bit_nxt[i])
            );
        end
    endgenerate

    always_comb begin
        state_d      = state_q;
        state_d.bits = bit_nxt;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_out = state_q.bits;

endmodule

// File: rtl/usr_checker.sv
module usr_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_right_in,
    input logic             ser_left_in,
    input logic [WIDTH-1:0] q_out
);

    // R1 R2
    load_takes_word_chk: assert property (@(posedge clk) disable iff (!clr_n)
        op_sel == 2'b11 |=> q_out == $past(par_in));

    // R3
    shift_toward_d_chk: assert property (@(posedge clk) disable iff (!clr_n)
        op_sel == 2'b01 |=> q_out == {$past(q_out[WIDTH-2:0]), $past(ser_right_in)});

    // R4
    shift_toward_a_chk: assert property (@(posedge clk) disable iff (!clr_n)
        op_sel == 2'b10 |=> q_out == {$past(ser_left_in), $past(q_out[WIDTH-1:1])});

    // R5
    hold_keeps_word_chk: assert property (@(posedge clk) disable iff (!clr_n)
        op_sel == 2'b00 |=> $stable(q_out));

    // R6 R7
    clear_zeroes_chk: assert property (@(posedge clk)
        !clr_n |-> q_out == '0);

endmodule

bind uni_shift_reg usr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .clr_n        (clr_n),
    .op_sel       (op_sel),
    .par_in       (par_in),
    .ser_right_in (ser_right_in),
    .ser_left_in  (ser_left_in),
    .q_out        (q_out)
);

// File: tb/uni_shift_reg_test.sv
module uni_shift_reg_test;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] par_in = '0;
    logic         ser_right_in = 1'b0;
    logic         ser_left_in = 1'b0;
    logic [W-1:0] q_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    uni_shift_reg #(.WIDTH(W)) uut (
        .clk          (clk),
        .clr_n        (clr_n),
        .op_sel       (op_sel),
        .par_in       (par_in),
        .ser_right_in (ser_right_in),
        .ser_left_in  (ser_left_in),
        .q_out        (q_out)
    );

    // entry: {op[1:0], par[3:0], ser_right, ser_left, expected[3:0]}
    localparam int NV = 15;
    localparam logic [11:0] VEC [NV] = '{
        {2'b11, 4'b1011, 1'b0, 1'b0, 4'b1011},  // R1 load
        {2'b11, 4'b0110, 1'b1, 1'b1, 4'b0110},  // R2 serial ignored
        {2'b01, 4'b0000, 1'b1, 1'b0, 4'b1101},  // R3
        {2'b01, 4'b1111, 1'b0, 1'b1, 4'b1010},  // R3
        {2'b10, 4'b0000, 1'b0, 1'b1, 4'b1101},  // R4
        {2'b10, 4'b1111, 1'b1, 1'b0, 4'b0110},  // R4
        {2'b00, 4'b1111, 1'b1, 1'b1, 4'b0110},  // R5
        {2'b00, 4'b1001, 1'b0, 1'b1, 4'b0110},  // R5
        {2'b01, 4'b0000, 1'b1, 1'b0, 4'b1101},  // R3
        {2'b10, 4'b0000, 1'b1, 1'b0, 4'b0110},  // R4
        {2'b11, 4'b1111, 1'b0, 1'b0, 4'b1111},  // R1
        {2'b01, 4'b0000, 1'b0, 1'b1, 4'b1110},  // R3
        {2'b01, 4'b0000, 1'b0, 1'b1, 4'b1100},  // R3
        {2'b01, 4'b0000, 1'b0, 1'b1, 4'b1000},  // R3
        {2'b01, 4'b0000, 1'b0, 1'b1, 4'b0000}   // R3 fully drained
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: q_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, sample at the next falling edge
    task automatic step(input logic [1:0] op, input logic [W-1:0] par, input logic sr, input logic sl);
        op_sel = op; par_in = par; ser_right_in = sr; ser_left_in = sl;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [1:0] op);
        case (op)
            2'b11:   return "R1/R2 load";
            2'b01:   return "R3 shift toward D";
            2'b10:   return "R4 shift toward A";
            default: return "R5 hold";
        endcase
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    initial begin
        logic [W-1:0] model;
        logic [W-1:0] seen;

        // reset state (R6)
        repeat (2) @(negedge clk);
        check("R6 reset state", q_out, '0);
        clr_n = 1'b1;

        // vector walk
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][11:10], VEC[k][9:6], VEC[k][5], VEC[k][4]);
            check(tag_of(VEC[k][11:10]), q_out, VEC[k][3:0]);
        end

        // R2 again: load with serial inputs opposite to the loaded end bits
        step(2'b11, 4'b0001, 1'b0, 1'b1);
        check("R2 load ignores serial", q_out, 4'b0001);

        // R6: clear between edges acts without a clock edge
        step(2'b11, 4'b1111, 1'b0, 1'b0);
        #1 clr_n = 1'b0;
        #1 check("R6 async clear", q_out, 4'b0000);

        // R7: edges while clear is held have no effect
        @(negedge clk);
        step(2'b11, 4'b1010, 1'b1, 1'b1);
        check("R7 load blocked by clear", q_out, 4'b0000);
        step(2'b01, 4'b0000, 1'b1, 1'b1);
        check("R7 shift blocked by clear", q_out, 4'b0000);
        clr_n = 1'b1;
        #1 check("R7 release keeps zero", q_out, 4'b0000);
        step(2'b01, 4'b0000, 1'b1, 1'b0);
        check("R7 resumes from zero", q_out, 4'b0001);

        // R8: a bit entered at A reaches D after WIDTH right shifts
        step(2'b11, 4'b0000, 1'b0, 1'b0);
        step(2'b01, 4'b0000, 1'b1, 1'b0);
        for (int k = 1; k < W; k++) step(2'b01, 4'b0000, 1'b0, 1'b0);
        check("R8 right-shift carry at D", {3'b000, q_out[W-1]}, 4'b0001);
        // and a bit entered at D reaches A after WIDTH left shifts
        step(2'b11, 4'b0000, 1'b0, 1'b0);
        step(2'b10, 4'b0000, 1'b0, 1'b1);
        for (int k = 1; k < W; k++) step(2'b10, 4'b0000, 1'b0, 1'b0);
        check("R8 left-shift carry at A", {3'b000, q_out[0]}, 4'b0001);

        // randomized run against a behavioural model, clears included (R1-style mix)
        model = q_out;
        for (int k = 0; k < 600; k++) begin
            logic [1:0]   op = 2'($urandom_range(0, 3));
            logic [W-1:0] pv = W'($urandom);
            logic         sr = 1'($urandom);
            logic         sl = 1'($urandom);
            clr_n = ($urandom_range(0, 15) != 0);
            if (!clr_n) model = '0;
            else begin
                case (op)
                    2'b11: model = pv;
                    2'b01: model = {model[W-2:0], sr};
                    2'b10: model = {sl, model[W-1:1]};
                    default: model = model;
                endcase
            end
            step(op, pv, sr, sl);
            seen = q_out;
            check(clr_n ? tag_of(op) : "R7 random clear", seen, model);
        end
        clr_n = 1'b1;

        summary();
    end

endmodule